// File: doc/BRIEF.md
# Four-Phase Interlocked Bus Bridge

This block moves single words between a requesting side and a small register file over a bus that has no shared timing. The two sides run on independent clocks. Each transfer is a four-phase exchange. The requester drives address (and, for a write, data) and waits a fixed number of settling cycles before it raises its request strobe. The responder reacts to the request and raises its acknowledge when its part is done. The requester then drops its request. The responder drops its acknowledge only after it sees the request fall.

Commands enter through a valid/ready port and results leave through a valid/ready port. A command is taken when `cmd_valid` and `cmd_ready` are both high at a rising edge of `clk_m`. A result stays on the output, unchanged, until `rsp_ready` is high at an edge. No new command is taken while a result waits.

The responder can be slowed with a programmable wait count, so fast and slow targets can share the bridge. The requester gives up after a programmable number of cycles without an acknowledge. In that case it reports a timeout and returns to idle once the bus is quiet.

Top module: `hs_bridge`

## Requirements
- R1: After reset, `cmd_ready` is 1, `rsp_valid` is 0, and every register in the file reads back 0.
- R2: A write command (`cmd_write`=1) stores `cmd_wdata` at `cmd_addr`, and a later read of that address returns it.
- R3: A read command (`cmd_write`=0) that completes returns the stored word on `rsp_rdata` with `rsp_timeout`=0.
- R4: Address, data and direction stay unchanged for at least SETTLE `clk_m` cycles before the request strobe rises, and they stay unchanged while it is high.
- R5: The responder keeps its acknowledge high until it sees the request low, and its read data stays unchanged while the acknowledge is high.
- R6: The request strobe falls only after a synchronized acknowledge, or after a timeout.
- R7: The transfer length follows the responder. Adding W responder wait cycles lengthens the transfer by at least W `clk_m` cycles, and the result is still correct.
- R8: If no acknowledge arrives within `tmo_limit` `clk_m` cycles of the request, the result carries `rsp_timeout`=1, and an interrupted write leaves the register unchanged.
- R9: A new command is taken only when both strobes are low. After a timeout, the bridge accepts and completes further commands.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the result holds steady and `cmd_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Requester clock |
| rst_m_n | input | 1 | Requester reset, active low |
| clk_s | input | 1 | Responder clock |
| rst_s_n | input | 1 | Responder reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Register index |
| cmd_wdata | input | DW | Write word |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result consumed |
| rsp_rdata | output | DW | Read word (0 after a write) |
| rsp_timeout | output | 1 | Transfer was abandoned |
| tmo_limit | input | TW | Acknowledge bound in `clk_m` cycles |
| slv_wait | input | TW | Extra responder cycles before it reacts |

## Verification
The assertions are checked on every cycle. They cover the settling interval before the request rises, and that address and data hold while the request is high. They also check that the request falls only after an acknowledge or a timeout, that the acknowledge is released only after the request is seen low, that read data is stable under the acknowledge, and that the result holds under back-pressure. Other behaviour can only be shown by the bench's scenarios across the two clock domains: that words written arrive in the file, that latency grows with responder wait, that an abandoned write leaves the register untouched, and that the bridge recovers after a timeout.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {M_IDLE, M_SETUP, M_REQ, M_RELEASE, M_RESP} mst_st_t;
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SETTLE, S_ACK} slv_st_t;
endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hs_master.sv
module hs_master import hs_pkg::*; #(
  parameter int AW = 2,
  parameter int DW = 8,
  parameter int SETTLE = 2,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_timeout,
  input  logic [TW-1:0] tmo_limit,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_write,
  output logic          bus_req,
  input  logic [DW-1:0] bus_rdata,
  input  logic          ack_sync
);
  localparam int SW = $clog2(SETTLE + 1);
  localparam int QW = SW + 1;

  mst_st_t       st;
  logic [SW-1:0] set_cnt;
  logic [TW-1:0] timer;

  assign cmd_ready = (st == M_IDLE) && !ack_sync && !bus_req;
  assign rsp_valid = (st == M_RESP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= M_IDLE;
      set_cnt     <= '0;
      timer       <= '0;
      bus_addr    <= '0;
      bus_wdata   <= '0;
      bus_write   <= 1'b0;
      bus_req     <= 1'b0;
      rsp_rdata   <= '0;
      rsp_timeout <= 1'b0;
    end else begin
      case (st)
        M_IDLE: if (cmd_valid && cmd_ready) begin
          bus_addr    <= cmd_addr;
          bus_wdata   <= cmd_wdata;
          bus_write   <= cmd_write;
          rsp_rdata   <= '0;
          rsp_timeout <= 1'b0;
          set_cnt     <= '0;
          st          <= M_SETUP;
        end
        M_SETUP: if (set_cnt == SW'(SETTLE - 1)) begin
          bus_req <= 1'b1;
          timer   <= '0;
          st      <= M_REQ;
        end else begin
          set_cnt <= set_cnt + 1'b1;
        end
        M_REQ: begin
          timer <= timer + 1'b1;
          if (ack_sync) begin
            if (!bus_write) rsp_rdata <= bus_rdata;
            bus_req <= 1'b0;
            st      <= M_RELEASE;
          end else if (timer >= tmo_limit) begin
            rsp_timeout <= 1'b1;
            bus_req     <= 1'b0;
            st          <= M_RELEASE;
          end
        end
        M_RELEASE: if (!ack_sync) st <= M_RESP;
        M_RESP:    if (rsp_ready) st <= M_IDLE;
        default:   st <= M_IDLE;
      endcase
    end
  end

  // Quiet-time tracker for the bus lines, used only by the checks below.
  logic [QW-1:0] quiet;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          write_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else begin
      addr_q  <= bus_addr;
      wdata_q <= bus_wdata;
      write_q <= bus_write;
      if (bus_addr != addr_q || bus_wdata != wdata_q || bus_write != write_q)
        quiet <= '0;
      else if (quiet != '1)
        quiet <= quiet + 1'b1;
    end
  end

  p_settle_before_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> (quiet >= QW'(SETTLE - 1)));
  p_bus_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && $past(bus_req)) |-> ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write)));
  p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> ($past(ack_sync) || rsp_timeout));
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_timeout) && !cmd_ready));
endmodule

// File: rtl/hs_slave.sv
module hs_slave import hs_pkg::*; #(
  parameter int AW = 2,
  parameter int DW = 8,
  parameter int SETTLE = 2,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_write,
  input  logic          req_sync,
  input  logic [TW-1:0] wait_cycles,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_ack
);
  localparam int DEPTH = 1 << AW;

  slv_st_t       st;
  logic [TW-1:0] cnt;
  logic [DW-1:0] regs [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      bus_rdata <= '0;
      bus_ack   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_sync) begin
          cnt <= '0;
          st  <= S_WAIT;
        end
        S_WAIT: if (!req_sync) begin
          st <= S_IDLE;
        end else if (cnt >= wait_cycles) begin
          cnt <= '0;
          if (bus_write) begin
            regs[bus_addr] <= bus_wdata;
            bus_ack        <= 1'b1;
            st             <= S_ACK;
          end else begin
            bus_rdata <= regs[bus_addr];
            st        <= S_SETTLE;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_SETTLE: if (!req_sync) begin
          bus_rdata <= '0;
          st        <= S_IDLE;
        end else if (cnt == TW'(SETTLE - 1)) begin
          bus_ack <= 1'b1;
          st      <= S_ACK;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_ACK: if (!req_sync) begin
          bus_ack   <= 1'b0;
          bus_rdata <= '0;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ack) |-> !$past(req_sync));
  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && $past(bus_ack)) |-> $stable(bus_rdata));
endmodule

// File: rtl/hs_bridge.sv
module hs_bridge #(
  parameter int AW = 2,
  parameter int DW = 8,
  parameter int SETTLE = 2,
  parameter int TW = 8
) (
  input  logic          clk_m,
  input  logic          rst_m_n,
  input  logic          clk_s,
  input  logic          rst_s_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_timeout,
  input  logic [TW-1:0] tmo_limit,
  input  logic [TW-1:0] slv_wait
);
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          bus_write, bus_req, bus_ack;
  logic          ack_sync, req_sync;

  hs_sync2 u_ack_sync (.clk(clk_m), .rst_n(rst_m_n), .d(bus_ack), .q(ack_sync));
  hs_sync2 u_req_sync (.clk(clk_s), .rst_n(rst_s_n), .d(bus_req), .q(req_sync));

  hs_master #(.AW(AW), .DW(DW), .SETTLE(SETTLE), .TW(TW)) u_mst (
    .clk(clk_m), .rst_n(rst_m_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_timeout(rsp_timeout), .tmo_limit(tmo_limit),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_write(bus_write),
    .bus_req(bus_req), .bus_rdata(bus_rdata), .ack_sync(ack_sync)
  );

  hs_slave #(.AW(AW), .DW(DW), .SETTLE(SETTLE), .TW(TW)) u_slv (
    .clk(clk_s), .rst_n(rst_s_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_write(bus_write),
    .req_sync(req_sync), .wait_cycles(slv_wait),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );
endmodule

// File: tb/hs_bridge_tb.sv
module hs_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int S_PERIOD   = CLK_PERIOD + 4;
  localparam int AW = 2, DW = 8, SETTLE = 2, TW = 8;

  logic clk_m = 0, clk_s = 0, rst_m_n = 0, rst_s_n = 0;
  logic cmd_valid = 0, cmd_write = 0, rsp_ready = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic [TW-1:0] tmo_limit = 8'd200, slv_wait = '0;
  logic cmd_ready, rsp_valid, rsp_timeout;
  logic [DW-1:0] rsp_rdata;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk_m = ~clk_m;
  always #(S_PERIOD/2)   clk_s = ~clk_s;

  hs_bridge #(.AW(AW), .DW(DW), .SETTLE(SETTLE), .TW(TW)) u_dut (
    .clk_m(clk_m), .rst_m_n(rst_m_n), .clk_s(clk_s), .rst_s_n(rst_s_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_timeout(rsp_timeout), .tmo_limit(tmo_limit), .slv_wait(slv_wait)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input int hold, output logic [DW-1:0] rd, output logic tmo, output int lat);
    @(negedge clk_m);
    cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    while (!cmd_ready) @(negedge clk_m);
    @(negedge clk_m);
    cmd_valid = 0;
    lat = 0;
    while (!rsp_valid) begin @(negedge clk_m); lat++; end
    rd = rsp_rdata; tmo = rsp_timeout;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk_m);
      check("R10 valid held", int'(rsp_valid), 1);
      check("R10 data held", int'(rsp_rdata), int'(rd));
      check("R10 cmd_ready low", int'(cmd_ready), 0);
    end
    rsp_ready = 1;
    @(negedge clk_m);
    rsp_ready = 0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] rd; logic tmo; int lat;
    repeat (3) @(negedge clk_m);
    check("R1 cmd_ready", int'(cmd_ready), 1);
    check("R1 rsp_valid", int'(rsp_valid), 0);
    xfer(1'b0, 2'd3, '0, 0, rd, tmo, lat);
    check("R1 reg reads zero", int'(rd), 0);
  endtask

  task automatic t_write_read;
    logic [DW-1:0] rd; logic tmo; int lat;
    for (int a = 0; a < (1 << AW); a++) begin
      xfer(1'b1, AW'(a), DW'(8'h5A ^ (a * 8'h13)), 0, rd, tmo, lat);
      check("R2 write no timeout", int'(tmo), 0);
    end
    for (int a = (1 << AW) - 1; a >= 0; a--) begin
      xfer(1'b0, AW'(a), '0, 0, rd, tmo, lat);
      check("R2 R3 read back", int'(rd), int'(DW'(8'h5A ^ (a * 8'h13))));
      check("R3 R6 no timeout", int'(tmo), 0);
      check("R4 latency exceeds settle", int'(lat > SETTLE), 1);
    end
  endtask

  task automatic t_slow;
    logic [DW-1:0] rd; logic tmo; int lat_fast, lat_slow;
    xfer(1'b1, 2'd1, 8'hC3, 0, rd, tmo, lat_fast);
    xfer(1'b0, 2'd1, '0, 0, rd, tmo, lat_fast);
    slv_wait = 8'd20;
    xfer(1'b0, 2'd1, '0, 0, rd, tmo, lat_slow);
    check("R7 R5 slow read data", int'(rd), 8'hC3);
    check("R7 slow no timeout", int'(tmo), 0);
    check("R7 latency grows", int'(lat_slow >= lat_fast + 20), 1);
    slv_wait = '0;
  endtask

  task automatic t_timeout;
    logic [DW-1:0] rd; logic tmo; int lat;
    xfer(1'b1, 2'd2, 8'h11, 0, rd, tmo, lat);
    tmo_limit = 8'd6; slv_wait = 8'd40;
    xfer(1'b1, 2'd2, 8'hEE, 0, rd, tmo, lat);
    check("R8 timeout flagged", int'(tmo), 1);
    tmo_limit = 8'd200; slv_wait = '0;
    repeat (10) @(negedge clk_m);
    check("R9 ready after timeout", int'(cmd_ready), 1);
    xfer(1'b0, 2'd2, '0, 0, rd, tmo, lat);
    check("R8 aborted write not stored", int'(rd), 8'h11);
    check("R9 recovered no timeout", int'(tmo), 0);
  endtask

  task automatic t_backpressure;
    logic [DW-1:0] rd; logic tmo; int lat;
    xfer(1'b1, 2'd0, 8'h7E, 0, rd, tmo, lat);
    xfer(1'b0, 2'd0, '0, 5, rd, tmo, lat);
    check("R10 held result", int'(rd), 8'h7E);
  endtask

  initial begin
    repeat (4) @(negedge clk_m);
    rst_m_n = 1; rst_s_n = 1;
    t_reset();
    t_write_read();
    t_slow();
    t_timeout();
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_m);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule